// File: doc/BRIEF.md
# Error-Resilient Slot Reorganization Encoder

This block takes a set of variable-length bit blocks and re-lays them into the same number of fixed-length slots. After that, the first bit of every block sits at a position that a decoder can compute from the total bit count alone. The blocks are written back to back into an input bit memory. A table of start offsets, holding one entry more than there are blocks, describes where each block begins and ends. A short list of search offsets controls which slot each block probes at each stage.

After a start pulse, the encoder sizes the slots from the bit total. It then runs one stage per slot. At every stage each block that still holds unplaced bits moves them, one per clock, into free space of a slot picked by the current offset. The result goes to a slot bit memory that is read through a registered port. In group mode the blocks are split into equal runs of consecutive blocks. Each run is sized and searched on its own, with the same offset list. The per-group bit totals are presented at completion as side information for the decoder.

Top module: `erec_slot_encoder`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and every field of `grp_totals` is 0.
- R2: In a group of M blocks holding Lg bits in total, slot k is Lg/M+1 bits long when k < Lg mod M and Lg/M bits long otherwise. The slots of a group lie end to end, starting at the input offset of the group's first block, so the output holds exactly as many bits as the input.
- R3: At stage 0, each block's leading min(block length, slot length) bits fill the start of its own slot in order, given search offset 0 at stage 0.
- R4: For stages s = 1 to M-1, the blocks are visited in ascending order i. Block i moves min(unplaced bits, free bits) of its next bits into slot (i + phi[s]) mod M at that slot's fill point. Block and slot pointers carry over from stage to stage.
- R5: When `done` fires, every input bit between table entry 0 and table entry N has been written to its place in the slot memory.
- R6: When `grp_mode` is 1 at start, the N blocks form NGRP groups of N/NGRP consecutive blocks. Each group is sized from its own total and searched modulo N/NGRP with the shared offset list, where offsets may exceed the group size.
- R7: At `done`, field g of `grp_totals` (bits g*AW up to g*AW+AW-1) holds table[(g+1)M] - table[gM]. In single mode field 0 holds table[N] - table[0] and the other fields hold 0.
- R8: A start seen while idle raises `busy` on the next cycle. `done` is a one-cycle pulse in the same cycle that `busy` falls. A start seen while busy has no effect on the run.
- R9: `done` appears G*(M*M+1)+L+1 clock edges after the edge that samples start, where G is the group count, M the group size and L the total bit count. Each moved bit costs one cycle and each block/slot visit costs one extra cycle.
- R10: `out_bit` shows the slot-memory bit at the `out_addr` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phi_we | input | 1 | Search-offset register write enable |
| phi_addr | input | IW | Stage index of the offset being written |
| phi_data | input | IW | Search offset value |
| tbl_we | input | 1 | Start-offset table write enable |
| tbl_addr | input | TW | Table entry index (0..N) |
| tbl_data | input | AW | Bit offset where the block begins (entry N is the end) |
| in_we | input | 1 | Input bit memory write enable |
| in_addr | input | RAW | Input bit address |
| in_bit | input | 1 | Input bit value |
| grp_mode | input | 1 | 1 selects independent groups, sampled with start |
| start | input | 1 | Begin a reorganization run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| grp_totals | output | NGRP*AW | Per-group bit totals, field g at g*AW |
| out_addr | input | RAW | Slot memory read address |
| out_bit | output | 1 | Slot memory read data, one cycle latency |

## Verification
The transfer path overlaps two actions in one cycle. While the next bit of a block is read from the input memory, the bit read in the previous cycle is written to the slot memory. That overlap also crosses pair boundaries, where the last pending write of one block/slot pair lands in the cycle that advances to the next pair. Cases with long blocks that spill through many slots, zero-length blocks, and offsets that wrap modulo the group size make back-to-back moves and immediate pair changes frequent. Each is judged by comparing every output bit with an arithmetic model, and by checking that the completion edge matches the cycle formula exactly.

// File: rtl/erec_pkg.sv
package erec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_FIN   = 2'd3
  } erec_state_e;
endpackage

// File: rtl/erec_bitram.sv
module erec_bitram #(
  parameter int RAW = 9
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic           wdata,
  input  logic [RAW-1:0] raddr,
  output logic           rdata
);
  localparam int DEPTH = 1 << RAW;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/erec_cfg_regs.sv
module erec_cfg_regs #(
  parameter int IW = 4,
  parameter int TW = 5,
  parameter int AW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      phi_we,
  input  logic [IW-1:0]             phi_addr,
  input  logic [IW-1:0]             phi_data,
  input  logic                      tbl_we,
  input  logic [TW-1:0]             tbl_addr,
  input  logic [AW-1:0]             tbl_data,
  output logic [(1<<IW)-1:0][IW-1:0] phi_tab,
  output logic [(1<<TW)-1:0][AW-1:0] off_tab
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phi_tab <= '0;
      off_tab <= '0;
    end else begin
      if (phi_we) phi_tab[phi_addr] <= phi_data;
      if (tbl_we) off_tab[tbl_addr] <= tbl_data;
    end
  end
endmodule

// File: rtl/erec_sizer.sv
module erec_sizer #(
  parameter int N  = 16,
  parameter int MG = 4,
  parameter int AW = 10
) (
  input  logic [AW-1:0] total,
  input  logic          grp,
  output logic [AW-1:0] quo,
  output logic [AW-1:0] rem
);
  localparam logic [AW-1:0] DIV_ALL = AW'(N);
  localparam logic [AW-1:0] DIV_GRP = AW'(MG);

  always_comb begin
    if (grp) begin
      quo = total / DIV_GRP;
      rem = total % DIV_GRP;
    end else begin
      quo = total / DIV_ALL;
      rem = total % DIV_ALL;
    end
  end
endmodule

// File: rtl/erec_slot_encoder.sv
module erec_slot_encoder
  import erec_pkg::*;
#(
  parameter int N       = 16,
  parameter int NGRP    = 4,
  parameter int MEMBITS = 512,
  localparam int RAW    = $clog2(MEMBITS),
  localparam int AW     = RAW + 1,
  localparam int IW     = $clog2(N),
  localparam int TW     = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phi_we,
  input  logic [IW-1:0]        phi_addr,
  input  logic [IW-1:0]        phi_data,
  input  logic                 tbl_we,
  input  logic [TW-1:0]        tbl_addr,
  input  logic [AW-1:0]        tbl_data,
  input  logic                 in_we,
  input  logic [RAW-1:0]       in_addr,
  input  logic                 in_bit,
  input  logic                 grp_mode,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [NGRP*AW-1:0]   grp_totals,
  input  logic [RAW-1:0]       out_addr,
  output logic                 out_bit
);
  localparam int MG = N / NGRP;
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int NP = 1 << IW;
  localparam int TP = 1 << TW;

  erec_state_e st;
  logic [GW-1:0] g;
  logic [IW-1:0] s, i;
  logic          mode_q;
  logic [NP-1:0][AW-1:0] bptr, sptr;
  logic [NGRP-1:0][AW-1:0] gtot;
  logic [AW-1:0] base_q, quo_q, rem_q;
  logic          pend_we;
  logic [RAW-1:0] pend_addr;
  logic          rd_bit;

  logic [NP-1:0][IW-1:0] phi_tab;
  logic [TP-1:0][AW-1:0] off_tab;

  erec_cfg_regs #(.IW(IW), .TW(TW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst),
    .phi_we(phi_we), .phi_addr(phi_addr), .phi_data(phi_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .phi_tab(phi_tab), .off_tab(off_tab)
  );

  // group geometry
  logic [AW-1:0] m_len;
  logic [TW-1:0] gfirst, glast;
  logic [AW-1:0] g_lo, g_hi, g_len, q_c, r_c;

  always_comb begin
    m_len  = mode_q ? AW'(MG) : AW'(N);
    gfirst = mode_q ? TW'(int'(g) * MG) : '0;
    glast  = mode_q ? TW'((int'(g) + 1) * MG) : TW'(N);
    g_lo   = off_tab[gfirst];
    g_hi   = off_tab[glast];
    g_len  = g_hi - g_lo;
  end

  erec_sizer #(.N(N), .MG(MG), .AW(AW)) u_sizer (
    .total(g_len), .grp(mode_q), .quo(q_c), .rem(r_c)
  );

  function automatic logic [AW-1:0] slot_pos(input logic [AW-1:0] base,
                                             input logic [AW-1:0] quo,
                                             input logic [AW-1:0] rem,
                                             input logic [AW-1:0] k);
    logic [AW-1:0] extra;
    extra = (k < rem) ? k : rem;
    return base + k * quo + extra;
  endfunction

  // pair selection for the current stage
  logic [IW:0]   sum_ij;
  logic [IW-1:0] j_c;
  logic [TW-1:0] bend_idx;
  logic [AW-1:0] bend_i, send_j, blk_left, slot_room;
  logic          do_move, last_i, last_s, last_g;

  always_comb begin
    sum_ij    = {1'b0, i} + {1'b0, phi_tab[s]};
    if (mode_q) j_c = IW'(sum_ij % (IW+1)'(MG));
    else        j_c = IW'(sum_ij % (IW+1)'(N));
    bend_idx  = gfirst + TW'(i) + TW'(1);
    bend_i    = off_tab[bend_idx];
    send_j    = slot_pos(base_q, quo_q, rem_q, AW'(j_c) + AW'(1));
    blk_left  = bend_i - bptr[i];
    slot_room = send_j - sptr[j_c];
    do_move   = (blk_left != '0) && (slot_room != '0);
    last_i    = (i == IW'(m_len - AW'(1)));
    last_s    = (s == IW'(m_len - AW'(1)));
    last_g    = mode_q ? (g == GW'(NGRP - 1)) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      g         <= '0;
      s         <= '0;
      i         <= '0;
      mode_q    <= 1'b0;
      bptr      <= '0;
      sptr      <= '0;
      gtot      <= '0;
      base_q    <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      pend_we   <= 1'b0;
      pend_addr <= '0;
    end else begin
      done    <= 1'b0;
      pend_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            st     <= ST_SETUP;
            g      <= '0;
            s      <= '0;
            i      <= '0;
            mode_q <= grp_mode;
            gtot   <= '0;
          end
        end
        ST_SETUP: begin
          base_q  <= g_lo;
          quo_q   <= q_c;
          rem_q   <= r_c;
          gtot[g] <= g_len;
          for (int k = 0; k < NP; k++) begin
            if (k < int'(m_len)) begin
              bptr[k] <= off_tab[gfirst + TW'(k)];
              sptr[k] <= slot_pos(g_lo, q_c, r_c, AW'(k));
            end
          end
          st <= ST_XFER;
        end
        ST_XFER: begin
          if (do_move) begin
            bptr[i]   <= bptr[i] + AW'(1);
            sptr[j_c] <= sptr[j_c] + AW'(1);
            pend_we   <= 1'b1;
            pend_addr <= sptr[j_c][RAW-1:0];
          end else if (last_i) begin
            i <= '0;
            if (last_s) begin
              s <= '0;
              if (last_g) st <= ST_FIN;
              else begin
                g  <= g + GW'(1);
                st <= ST_SETUP;
              end
            end else begin
              s <= s + IW'(1);
            end
          end else begin
            i <= i + IW'(1);
          end
        end
        ST_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign grp_totals = gtot;

  erec_bitram #(.RAW(RAW)) u_in_ram (
    .clk(clk), .we(in_we), .waddr(in_addr), .wdata(in_bit),
    .raddr(bptr[i][RAW-1:0]), .rdata(rd_bit)
  );

  erec_bitram #(.RAW(RAW)) u_out_ram (
    .clk(clk), .we(pend_we), .waddr(pend_addr), .wdata(rd_bit),
    .raddr(out_addr), .rdata(out_bit)
  );

  // R8: completion handshake
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start) |=> (busy && !done));
  // R2: sizer splits the group total exactly
  p_sizing_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETUP) |-> ((q_c * m_len + r_c == g_len) && (r_c < m_len)));
  // R4: slot writes only follow a transfer cycle
  p_wr_src_r4: assert property (@(posedge clk) disable iff (rst)
    pend_we |-> $past(st == ST_XFER));

  // R5: every block and slot of the last group is exhausted at the end
  always_ff @(posedge clk) begin
    if (!rst && st == ST_FIN) begin
      for (int k = 0; k < NP; k++) begin
        if (k < int'(m_len)) begin
          p_drained_r5: assert (bptr[k] == off_tab[gfirst + TW'(k) + TW'(1)]);
          p_filled_r5: assert (sptr[k] == slot_pos(base_q, quo_q, rem_q, AW'(k) + AW'(1)));
        end
      end
    end
  end
endmodule

// File: tb/tb_erec_slot_encoder.sv
`timescale 1ns/1ps
module tb_erec_slot_encoder;
  localparam int N = 6;
  localparam int NGRP = 2;
  localparam int MEMBITS = 64;
  localparam int MG = N / NGRP;
  localparam int RAW = 6;
  localparam int AW = 7;
  localparam int IW = 3;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi_we = 0; logic [IW-1:0] phi_addr = 0; logic [IW-1:0] phi_data = 0;
  logic tbl_we = 0; logic [TW-1:0] tbl_addr = 0; logic [AW-1:0] tbl_data = 0;
  logic in_we = 0; logic [RAW-1:0] in_addr = 0; logic in_bit = 0;
  logic grp_mode = 0, start = 0;
  logic busy, done, out_bit;
  logic [NGRP*AW-1:0] grp_totals;
  logic [RAW-1:0] out_addr = 0;

  always #2.5 clk = ~clk;

  erec_slot_encoder #(.N(N), .NGRP(NGRP), .MEMBITS(MEMBITS)) dut (
    .clk(clk), .rst(rst),
    .phi_we(phi_we), .phi_addr(phi_addr), .phi_data(phi_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_we(in_we), .in_addr(in_addr), .in_bit(in_bit),
    .grp_mode(grp_mode), .start(start), .busy(busy), .done(done),
    .grp_totals(grp_totals), .out_addr(out_addr), .out_bit(out_bit)
  );

  int nchk = 0, nerr = 0;
  int blen[N];
  int phiv[N];
  int base0;
  bit inmem[MEMBITS];
  bit expb[MEMBITS];
  int tagv[MEMBITS];
  bit slast[MEMBITS];
  int exp_tot[NGRP];
  int exp_cyc, tot_len;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic build_model(input bit gm);
    int ng, m, bp[N], be[N], sp[N], se[N];
    ng = gm ? NGRP : 1;
    m  = gm ? MG : N;
    tot_len = 0;
    for (int k = 0; k < N; k++) tot_len += blen[k];
    for (int a = 0; a < MEMBITS; a++) begin tagv[a] = 0; slast[a] = 0; expb[a] = 0; end
    for (int g = 0; g < NGRP; g++) exp_tot[g] = 0;
    exp_cyc = ng * (m * m + 1) + tot_len + 1;
    for (int g = 0; g < ng; g++) begin
      int f, gb, gl, q, r, run;
      f = g * m;
      gb = base0;
      for (int k = 0; k < f; k++) gb += blen[k];
      gl = 0;
      for (int k = 0; k < m; k++) gl += blen[f + k];
      exp_tot[g] = gl;
      q = gl / m; r = gl % m;
      run = gb;
      for (int k = 0; k < m; k++) begin
        bp[k] = run; run += blen[f + k]; be[k] = run;
        sp[k] = gb + k * q + ((k < r) ? k : r);
        se[k] = sp[k] + q + ((k < r) ? 1 : 0);
        if (se[k] > sp[k]) slast[se[k] - 1] = 1;
      end
      for (int s = 0; s < m; s++) begin
        for (int i = 0; i < m; i++) begin
          int j, n;
          j = (i + phiv[s]) % m;
          n = be[i] - bp[i];
          if (se[j] - sp[j] < n) n = se[j] - sp[j];
          for (int t = 0; t < n; t++) begin
            expb[sp[j]] = inmem[bp[i]];
            tagv[sp[j]] = (s == 0) ? 3 : (gm ? 6 : 4);
            bp[i]++; sp[j]++;
          end
        end
      end
    end
  endtask

  task automatic run_case(input string name, input bit gm, input bit poke, input int seed);
    int acc, cnt, bad;
    string tg;
    acc = base0;
    for (int k = 0; k <= N; k++) begin
      tbl_we = 1; tbl_addr = TW'(k); tbl_data = AW'(acc);
      tick();
      if (k < N) acc += blen[k];
    end
    tbl_we = 0;
    for (int k = 0; k < N; k++) begin
      phi_we = 1; phi_addr = IW'(k); phi_data = IW'(phiv[k]);
      tick();
    end
    phi_we = 0;
    for (int a = 0; a < MEMBITS; a++) begin
      inmem[a] = (((a * 37 + seed * 11) % 7) < 3);
      in_we = 1; in_addr = RAW'(a); in_bit = inmem[a];
      tick();
    end
    in_we = 0;
    build_model(gm);
    grp_mode = gm; start = 1;
    tick();
    start = 0; grp_mode = 0;
    chk(busy == 1'b1, "R8", {name, " busy after start"}, int'(busy), 1);
    cnt = 0;
    while (!done && cnt < 5000) begin
      tick();
      cnt++;
      start = (poke && cnt == 5) ? 1'b1 : 1'b0;
    end
    start = 0;
    chk(cnt == exp_cyc, "R9", {name, " cycles to done"}, cnt, exp_cyc);
    chk(busy == 1'b0, "R8", {name, " busy low with done"}, int'(busy), 0);
    for (int g = 0; g < NGRP; g++)
      chk(int'(grp_totals[g*AW +: AW]) == exp_tot[g], "R7", {name, " group total"},
          int'(grp_totals[g*AW +: AW]), exp_tot[g]);
    tick();
    chk(done == 1'b0, "R8", {name, " done is one pulse"}, int'(done), 0);
    chk(busy == 1'b0, "R8", {name, " start while busy ignored"}, int'(busy), 0);
    bad = 0;
    for (int p = base0; p < base0 + tot_len; p++) begin
      out_addr = RAW'(p);
      tick();
      if (slast[p]) tg = "R2";
      else if (tagv[p] == 3) tg = "R3";
      else if (tagv[p] == 6) tg = "R6";
      else if (tagv[p] == 4) tg = "R4";
      else tg = "R10";
      if (out_bit != expb[p]) bad++;
      chk(out_bit == expb[p], tg, $sformatf("%s bit %0d", name, p), int'(out_bit), int'(expb[p]));
    end
    chk(bad == 0, "R5", {name, " all bits placed"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(grp_totals == '0, "R1", "reset totals", int'(grp_totals), 0);

    blen = '{10, 5, 4, 7, 2, 8}; phiv = '{0, 1, 2, 3, 4, 5}; base0 = 0;
    run_case("spill_single", 1'b0, 1'b0, 1);
    run_case("spill_groups", 1'b1, 1'b0, 4);

    blen = '{0, 13, 1, 0, 3, 9}; phiv = '{0, 3, 1, 5, 2, 4}; base0 = 5;
    run_case("sparse_offset", 1'b0, 1'b0, 2);
    phiv = '{0, 4, 5, 1, 2, 3};
    run_case("wrap_groups_poke", 1'b1, 1'b1, 3);

    blen = '{0, 0, 0, 0, 0, 0}; base0 = 0;
    run_case("empty", 1'b0, 1'b0, 5);

    blen = '{20, 0, 0, 0, 0, 0}; phiv = '{0, 1, 2, 3, 4, 5};
    run_case("one_long", 1'b0, 1'b1, 6);

    blen = '{1, 1, 9, 2, 0, 0}; phiv = '{0, 2, 1, 5, 3, 4}; base0 = 2;
    run_case("uneven_groups", 1'b1, 1'b0, 7);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule